// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register Block

This block is the control register file of an audio codec as seen from a simple memory-mapped bus. A bus master issues read and write strobes with a byte address, 32-bit write data and 32-bit read data. The address decodes into sixteen 32-bit direct slots. Slot 0 holds a pointer, and slot 1 is a window onto a second bank of thirty-two 8-bit indirect entries. Software sets the pointer, then reads or writes the window to reach one indirect entry.

Several locations carry fixed behaviour. Some entries are read-only and hold version codes. One entry is write-only. One entry merges a single writable bit into a constant code. One direct slot is read-only. A control slot can trigger a soft reset of the whole block. Read data is registered. The interrupt output is tied inactive.

Top module: `codec_ctl_regs`

## Requirements
- R1: After the asynchronous active-low reset, every direct slot reads zero and every indirect entry reads zero, except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R2: The slot number is byte address bits [5:2]. Slots 0, 3 and 5 to 15 store all 32 written bits. A read returns its data on rdata_o one clock after the read strobe. rdata_o holds its value while no read is issued. When a read and a write hit the same location in one cycle, the read returns the value from before the write.
- R3: The indirect pointer is bits [4:0] of slot 0. A read of slot 1 returns the selected entry zero-extended to 32 bits. A write to slot 1 stores write data bits [7:0] into the selected entry.
- R4: A read of indirect entry 3 through slot 1 returns zero, whatever was written to that entry.
- R5: Writes through slot 1 to indirect entries 11 and 25 leave those entries unchanged.
- R6: A write to indirect entry 12 stores (write data AND 0x40) OR 0x8A.
- R7: Writes to direct slot 2 are dropped, so slot 2 always reads zero.
- R8: A write to direct slot 4 stores the write data AND 0x7F. When bit 0 of that write data is 1, every other direct slot and every indirect entry returns to its R1 value in the same clock.
- R9: irq_o is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Byte address in the 0x40-byte window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, held low |

## Verification
The assertions check on every cycle that the interrupt stays low and that the bits of entry 12 outside bit 6 always form the constant code. They also check the one-cycle read latency for direct slots, that reads of entry 3 return zero, that the read-only entries hold across window writes, and the masking of slot 4. Only the bench scenarios can show the full reset value set, the wipe of every location by a soft reset, and the old-value return when a read and a write collide. Those scenarios compare a behavioural model of all 48 locations against rdata_o each clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DIR_SLOTS   = 16;
  localparam int DW          = 32;
  localparam int IND_ENTRIES = 32;
  localparam int IW          = 8;
  localparam int SLOTW       = $clog2(DIR_SLOTS);
  localparam int AW          = SLOTW + 2;
  localparam int IDXW        = $clog2(IND_ENTRIES);

  localparam int SLOT_INDEX  = 0;
  localparam int SLOT_WINDOW = 1;
  localparam int SLOT_RO     = 2;
  localparam int SLOT_CTRL   = 4;

  localparam int ENT_WO      = 3;
  localparam int ENT_RO      = 11;
  localparam int ENT_CODEC   = 12;
  localparam int ENT_CHIP    = 25;

  localparam logic [IW-1:0] CODEC_CODE = 8'h8A;
  localparam logic [IW-1:0] CHIP_CODE  = 8'hA0;
  localparam logic [IW-1:0] CODEC_KEEP = 8'h40;
  localparam logic [DW-1:0] CTRL_MASK  = 32'h7F;

  function automatic logic [IW-1:0] ind_init(int i);
    if (i == ENT_CODEC) return CODEC_CODE;
    if (i == ENT_CHIP)  return CHIP_CODE;
    return '0;
  endfunction
endpackage

// File: rtl/ccr_direct_bank.sv
module ccr_direct_bank
  import ccr_pkg::*;
#(
  parameter int N = DIR_SLOTS,
  parameter int W = DW,
  localparam int SW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         we_i,
  input  logic [SW-1:0] slot_i,
  input  logic [W-1:0]  wdata_i,
  output logic [N*W-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == SLOT_WINDOW || g == SLOT_RO) begin : g_none
      // window has no direct storage; read-only slot is never loaded
      assign q_o[g*W +: W] = '0;
    end else begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (we_i && slot_i == SW'(g)) begin
          if (g == SLOT_CTRL) q <= wdata_i & CTRL_MASK[W-1:0];
          else                q <= wdata_i;
        end else if (soft_rst_i) begin
          q <= '0;
        end
      end
      assign q_o[g*W +: W] = q;
    end
  end
endmodule

// File: rtl/ccr_indirect_bank.sv
module ccr_indirect_bank
  import ccr_pkg::*;
#(
  parameter int N = IND_ENTRIES,
  parameter int W = IW,
  localparam int XW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          we_i,
  input  logic [XW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [N*W-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [W-1:0] INIT = ind_init(g);
    localparam bit RO = (g == ENT_RO) || (g == ENT_CHIP);
    logic [W-1:0] q;
    logic [W-1:0] nxt;
    always_comb begin
      if (g == ENT_CODEC) nxt = (wdata_i & CODEC_KEEP) | CODEC_CODE;
      else                nxt = wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= INIT;
      else if (soft_rst_i)                  q <= INIT;
      else if (!RO && we_i && idx_i == XW'(g)) q <= nxt;
    end
    assign q_o[g*W +: W] = q;
  end
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import ccr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [SLOTW-1:0]         slot;
  logic                     soft_rst;
  logic                     win_we;
  logic                     dir_we;
  logic [IDXW-1:0]          idx;
  logic [DIR_SLOTS*DW-1:0]  dir_flat;
  logic [IND_ENTRIES*IW-1:0] ind_flat;
  logic [IW-1:0]            ind_sel;
  logic [DW-1:0]            rd_mux;
  logic [DW-1:0]            rdata_q;
  logic                     unused_lo;

  assign slot      = addr_i[AW-1:2];
  assign unused_lo = ^addr_i[1:0];
  assign soft_rst  = wr_i && slot == SLOTW'(SLOT_CTRL) && wdata_i[0];
  assign win_we    = wr_i && slot == SLOTW'(SLOT_WINDOW);
  assign dir_we    = wr_i;
  assign idx       = dir_flat[SLOT_INDEX*DW +: IDXW];

  ccr_direct_bank #(.N(DIR_SLOTS), .W(DW)) i_dir (
    .clk_i, .rst_ni,
    .soft_rst_i(soft_rst),
    .we_i      (dir_we),
    .slot_i    (slot),
    .wdata_i   (wdata_i),
    .q_o       (dir_flat)
  );

  ccr_indirect_bank #(.N(IND_ENTRIES), .W(IW)) i_ind (
    .clk_i, .rst_ni,
    .soft_rst_i(soft_rst),
    .we_i      (win_we),
    .idx_i     (idx),
    .wdata_i   (wdata_i[IW-1:0]),
    .q_o       (ind_flat)
  );

  assign ind_sel = (idx == IDXW'(ENT_WO)) ? '0 : ind_flat[idx*IW +: IW];

  always_comb begin
    if (slot == SLOTW'(SLOT_WINDOW)) rd_mux = DW'(ind_sel);
    else                             rd_mux = dir_flat[slot*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = 1'b0;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rd_i,
  input logic                      wr_i,
  input logic [AW-1:0]             addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic [DW-1:0]             rdata_o,
  input logic                      irq_o,
  input logic [IDXW-1:0]           idx_i,
  input logic [DIR_SLOTS*DW-1:0]   dir_i,
  input logic [IND_ENTRIES*IW-1:0] ind_i
);
  logic [SLOTW-1:0] slot;
  logic [DW-1:0]    dir_sel;
  assign slot    = addr_i[AW-1:2];
  assign dir_sel = dir_i[slot*DW +: DW];

  a_r9_irq_low: assert property (@(posedge clk_i) irq_o == 1'b0);

  a_r6_codec_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i[ENT_CODEC*IW +: IW] & ~CODEC_KEEP) == CODEC_CODE);

  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && slot != SLOTW'(SLOT_WINDOW) |=> rdata_o == $past(dir_sel));

  a_r4_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && slot == SLOTW'(SLOT_WINDOW) && idx_i == IDXW'(ENT_WO) |=> rdata_o == '0);

  a_r5_ro_entries_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && slot == SLOTW'(SLOT_WINDOW) &&
    (idx_i == IDXW'(ENT_RO) || idx_i == IDXW'(ENT_CHIP))
    |=> $stable(ind_i[ENT_RO*IW +: IW]) && $stable(ind_i[ENT_CHIP*IW +: IW]));

  a_r8_ctrl_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && slot == SLOTW'(SLOT_CTRL)
    |=> dir_i[SLOT_CTRL*DW +: DW] == ($past(wdata_i) & CTRL_MASK));

  a_r7_ro_slot_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i[SLOT_RO*DW +: DW] == '0);
endmodule

bind codec_ctl_regs ccr_checker u_ccr_checker (
  .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
  .idx_i(idx), .dir_i(dir_flat), .ind_i(ind_flat)
);

// File: tb/test_codec_ctl_regs.sv
`timescale 1ns/1ps
module test_codec_ctl_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd = 0, wr = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_dir [16];
  logic [7:0]  m_ind [32];
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  codec_ctl_regs i_codec_ctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_dir[i] = '0;
    for (int i = 0; i < 32; i++) m_ind[i] = '0;
    m_ind[12] = 8'h8A;
    m_ind[25] = 8'hA0;
  endtask

  function automatic logic [31:0] model_read(int s);
    int ix;
    if (s != 1) return m_dir[s];
    ix = m_dir[0] & 31;
    if (ix == 3) return '0;
    return {24'h0, m_ind[ix]};
  endfunction

  task automatic model_write(int s, logic [31:0] d);
    int ix;
    ix = m_dir[0] & 31;
    case (s)
      1: begin
        if (ix == 12) m_ind[ix] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 11 && ix != 25) m_ind[ix] = d[7:0];
      end
      2: ;
      4: begin
        if (d[0]) model_reset();
        m_dir[4] = d & 32'h7F;
      end
      default: m_dir[s] = d;
    endcase
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; compares against the model after the edge
  task automatic cyc(bit r, bit w, int s, logic [31:0] d, string req);
    @(negedge clk);
    rd = r; wr = w; addr = 6'(s << 2); wdata = d;
    @(posedge clk);
    if (r) m_rdata = model_read(s);
    if (w) model_write(s, d);
    #1;
    check(req, rdata, m_rdata);
    check("R9", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  task automatic rd_ind(int ix, string req);
    cyc(0, 1, 0, 32'(ix), req);
    cyc(1, 0, 1, 0, req);
  endtask

  task automatic wr_ind(int ix, logic [31:0] d, string req);
    cyc(0, 1, 0, 32'(ix), req);
    cyc(0, 1, 1, d, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    m_rdata = '0;
    #12;
    check("R1", rdata, 32'h0);
    check("R9", {31'h0, irq}, 32'h0);
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 16; s++) cyc(1, 0, s, 0, "R1");
    for (int i = 0; i < 32; i++) rd_ind(i, "R1");
    // R2 direct storage, latency, hold, collision
    for (int s = 3; s < 16; s++)
      if (s != 4) cyc(0, 1, s, 32'hA5C3_0000 ^ (32'(s) * 32'h0101_0111), "R2");
    for (int s = 3; s < 16; s++) if (s != 4) cyc(1, 0, s, 0, "R2");
    cyc(0, 0, 7, 0, "R2");
    cyc(1, 1, 9, 32'hDEAD_BEEF, "R2");
    cyc(1, 0, 9, 0, "R2");
    cyc(1, 1, 0, 32'hFFFF_FFE6, "R2");
    cyc(1, 0, 1, 0, "R3");
    // R3 indirect window
    for (int i = 0; i < 32; i++) wr_ind(i, 32'hFFFF_FF00 | 32'(i * 7 + 1), "R3");
    for (int i = 0; i < 32; i++) rd_ind(i, "R3");
    // R4 write-only entry
    wr_ind(3, 32'h5A, "R4");
    rd_ind(3, "R4");
    // R5 read-only entries
    wr_ind(11, 32'h77, "R5");
    rd_ind(11, "R5");
    wr_ind(25, 32'h33, "R5");
    rd_ind(25, "R5");
    // R6 masked codec entry
    wr_ind(12, 32'hFF, "R6");
    rd_ind(12, "R6");
    wr_ind(12, 32'h00, "R6");
    rd_ind(12, "R6");
    wr_ind(12, 32'h40, "R6");
    rd_ind(12, "R6");
    // R7 read-only slot
    cyc(0, 1, 2, 32'hFFFF_FFFF, "R7");
    cyc(1, 0, 2, 0, "R7");
    // R8 control slot
    cyc(0, 1, 4, 32'hFFFF_FFFE, "R8");
    cyc(1, 0, 4, 0, "R8");
    cyc(1, 0, 5, 0, "R8");
    cyc(0, 1, 0, 32'd20, "R8");
    cyc(1, 1, 4, 32'h1234_5681, "R8");
    for (int s = 0; s < 16; s++) cyc(1, 0, s, 0, "R8");
    for (int i = 0; i < 32; i++) rd_ind(i, "R8");
    cyc(1, 0, 4, 0, "R8");
    finish_run();
  end
endmodule